// File: doc/BRIEF.md
# HDLC Receive Controller with Packet FIFO

This block receives a serial line, one bit per cycle in which `bit_en_i` is high, and pulls HDLC frames out of it. It hunts for the 7Eh flag, removes the zeros the sender stuffed after runs of five 1s, recognises aborts and checks each frame's 16-bit CRC. Each payload byte is stored in a 256-entry show-ahead FIFO with a 4-bit tag. The tag marks the first and last byte of a packet and, on the last byte, how the packet ended. The two check bytes are never stored.

A host drains the FIFO one entry per `rd_i` pulse. It watches five sticky flags: packet start, packet end, abort seen, high watermark and overflow. It clears any of them by pulsing the matching `clr_i` bit. After an overflow the block stops storing packets until the host has emptied the FIFO or reset the block. Packets that arrive in the meantime are lost whole, so the FIFO never holds a fragment that starts after the gap.

Top module: `hdlc_rx_core`

## Requirements
- R1: A frame opens after a 7Eh flag, and bytes are assembled least significant bit first. A run of flags with no data between them stores nothing.
- R2: Inside a frame, a 0 that follows five consecutive 1s is dropped. A 0 that follows six 1s completes a flag, so payloads containing 7Eh, FFh or long runs of 1s are stored unchanged.
- R3: The CRC uses x^16+x^12+x^5+1 in bit-reversed form (8408h), preset to FFFFh. The sender transmits it complemented, low byte first. A frame closed by a flag is good when it has at least three bytes, ends on a byte boundary, and leaves the residue F0B8h over payload plus check bytes. Any other closed frame is marked as a CRC error.
- R4: Each entry has a tag on `rd_tag_o`:
  - bit 0 is set on the first byte of a packet;
  - bit 1 is set on the last byte;
  - bits 3:2 give the end status: 0 good, 1 CRC error or short frame, 2 aborted.
  - Bytes that are not last always carry status 0.
- R5: Seven consecutive 1s, inside or outside a frame, set `status_o[2]`.
- R6: Writes to the FIFO trail reception by up to three bytes. If k≥1 bytes of a frame are complete when an abort arrives, bytes 0 through k−min(k,3) are stored, and the last of them is tagged last with status 2. If no byte is complete, nothing is stored.
- R7: The FIFO shows its oldest entry on `rd_data_o`/`rd_tag_o` while `empty_o` is low, and each `rd_i` pops one entry. A read while empty is ignored. A read and a write in the same cycle both take effect.
- R8: `status_o[0]` sets when the first byte of a packet is stored, and `status_o[1]` sets when the last byte of a packet is stored.
- R9: `status_o[3]` sets while the FIFO level exceeds 32·`hwm_sel_i`+16 entries.
- R10: Overflow behaviour:
  - A byte that arrives while 256 entries are held is dropped and sets `status_o[4]`.
  - The rest of that packet is dropped.
  - Every later packet is dropped until the FIFO has become empty.
- R11: Status bits are sticky and clear on a `clr_i` pulse in the matching bit. When a set event and a clear fall in the same cycle, the set wins.
- R12: After reset the FIFO is empty and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Line bit valid in this cycle |
| bit_i | input | 1 | Serial line bit |
| rd_i | input | 1 | Pop one FIFO entry |
| hwm_sel_i | input | 3 | High watermark select |
| clr_i | input | 5 | Write-1-to-clear pulses for the status bits |
| rd_data_o | output | 8 | Oldest stored byte |
| rd_tag_o | output | 4 | Tag of the oldest byte: {status[1:0], last, first} |
| empty_o | output | 1 | FIFO holds no entry |
| status_o | output | 5 | Sticky flags: 0 start, 1 end, 2 abort, 3 watermark, 4 overflow |

## Verification
The collision that matters most is a status event and a host clear of the same bit landing on the same edge. The bench provokes it by holding the clear pulse for packet start and packet end high on every bit of a whole frame, closing flag included. The packet-end event therefore falls on an edge where its clear is also asserted, while the packet-start flag is set mid-frame and then cleared on later bits. After the frame, the bench expects the end flag set and the start flag cleared. Reads are also issued at random while frames stream in, so that pops and pushes share edges. Every popped entry is compared against the bench's model queue.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    PS_OK    = 2'd0,
    PS_CRC   = 2'd1,
    PS_ABORT = 2'd2
  } pkt_stat_e;

  typedef struct packed {
    pkt_stat_e stat;
    logic      last;
    logic      first;
  } pkt_tag_t;

  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_GOOD     = 16'hF0B8;

  localparam int ST_START = 0;
  localparam int ST_END   = 1;
  localparam int ST_ABORT = 2;
  localparam int ST_HWM   = 3;
  localparam int ST_OVF   = 4;
  localparam int ST_W     = 5;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES  = 2,
  parameter int ABORT_ONES = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       bit_i,
  output logic       wr_req_o,
  output logic [7:0] wr_data_o,
  output pkt_tag_t   wr_tag_o,
  output logic       abort_o
);
  localparam int HOLD       = FCS_BYTES + 1;
  localparam int HW         = $clog2(HOLD + 1);
  localparam int OW         = $clog2(ABORT_ONES + 1);
  localparam int FLAG_ONES  = ABORT_ONES - 1;
  localparam int STUFF_ONES = ABORT_ONES - 2;

  logic [OW-1:0] ones_q;
  logic          in_frame_q, first_q;
  logic [2:0]    bcnt_q;
  logic [6:0]    sr_q;
  logic [15:0]   crc_q;
  logic [7:0]    hold_q [HOLD];
  logic [HW-1:0] hcnt_q;

  logic flag_bit, abort_bit, stuff_bit, data_bit, byte_done;
  logic hold_full, close_ev, abort_ev, push_mid, good;
  logic [7:0] new_byte;

  assign flag_bit  = bit_en_i && !bit_i && (ones_q == OW'(FLAG_ONES));
  assign abort_bit = bit_en_i &&  bit_i && (ones_q == OW'(FLAG_ONES));
  assign stuff_bit = !bit_i && (ones_q == OW'(STUFF_ONES));
  assign data_bit  = bit_en_i && in_frame_q && !flag_bit && !abort_bit && !stuff_bit;
  assign new_byte  = {bit_i, sr_q};
  assign byte_done = data_bit && (bcnt_q == 3'd7);
  assign hold_full = (hcnt_q == HW'(HOLD));

  assign close_ev = flag_bit  && in_frame_q && (hcnt_q != '0);
  assign abort_ev = abort_bit && in_frame_q && (hcnt_q != '0);
  assign push_mid = byte_done && hold_full;
  // closing flag leaves its own 7 bits in the assembler when byte-aligned
  assign good     = hold_full && (bcnt_q == 3'd7) && (crc_q == CRC_GOOD);

  assign wr_req_o       = push_mid || close_ev || abort_ev;
  assign wr_data_o      = hold_q[0];
  assign wr_tag_o.first = first_q;
  assign wr_tag_o.last  = close_ev || abort_ev;
  assign wr_tag_o.stat  = abort_ev ? PS_ABORT : (close_ev && !good) ? PS_CRC : PS_OK;
  assign abort_o        = abort_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      first_q    <= 1'b1;
      bcnt_q     <= '0;
      sr_q       <= '0;
      crc_q      <= CRC_PRESET;
      hcnt_q     <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
    end else if (bit_en_i) begin
      ones_q <= !bit_i ? '0 : (ones_q == OW'(ABORT_ONES)) ? ones_q : ones_q + OW'(1);
      if (flag_bit) begin
        in_frame_q <= 1'b1;
        first_q    <= 1'b1;
        bcnt_q     <= '0;
        crc_q      <= CRC_PRESET;
        hcnt_q     <= '0;
      end else if (abort_bit) begin
        in_frame_q <= 1'b0;
      end else if (data_bit) begin
        sr_q   <= new_byte[7:1];
        bcnt_q <= bcnt_q + 3'd1;
        if (bcnt_q == 3'd7) begin
          crc_q <= crc16_byte(crc_q, new_byte);
          if (hold_full) begin
            for (int i = 0; i < HOLD - 1; i++) hold_q[i] <= hold_q[i+1];
            hold_q[HOLD-1] <= new_byte;
            first_q        <= 1'b0;
          end else begin
            hold_q[hcnt_q] <= new_byte;
            hcnt_q         <= hcnt_q + HW'(1);
          end
        end
      end
    end
  end

  // R4: only a closing write may carry a non-zero end status
  a_r4_mid_status_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_tag_o.last) |-> (wr_tag_o.stat == PS_OK));

  // R6: an abort always drops the receiver out of the frame
  a_r6_abort_leaves_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !in_frame_q);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [W-1:0]               wr_data_i,
  input  logic                       rd_i,
  output logic [W-1:0]               rd_data_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH):0]     level_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic push, pop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == (AW+1)'(DEPTH));
  assign level_o   = cnt_q;
  assign push      = wr_i && !full_o;
  assign pop       = rd_i && !empty_o;
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + AW'(1);
      if (pop)  rp_q <= rp_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10: the controller never pushes into a full FIFO
  a_r10_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_i);

  // R7: reading an empty FIFO without a push leaves it empty
  a_r7_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !wr_i) |=> empty_o);

endmodule

// File: rtl/hdlc_rx_core.sv
module hdlc_rx_core
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  input  logic            bit_i,
  input  logic            rd_i,
  input  logic [2:0]      hwm_sel_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [7:0]      rd_data_o,
  output logic [3:0]      rd_tag_o,
  output logic            empty_o,
  output logic [ST_W-1:0] status_o
);
  localparam int LW      = $clog2(DEPTH) + 1;
  localparam int WM_STEP = DEPTH / 8;
  localparam int TAG_W   = $bits(pkt_tag_t);
  localparam int ENT_W   = 8 + TAG_W;

  logic       wr_req, abort_ev;
  logic [7:0] wr_data;
  pkt_tag_t   wr_tag;

  hdlc_rx_deframer u_deframer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .bit_i    (bit_i),
    .wr_req_o (wr_req),
    .wr_data_o(wr_data),
    .wr_tag_o (wr_tag),
    .abort_o  (abort_ev)
  );

  logic [LW-1:0]    level, hwm_thr;
  logic [ENT_W-1:0] ent;
  logic fifo_full, fifo_empty, fifo_wr;
  logic drop_q, lock_q, drop_eff, ovf_ev;
  logic [ST_W-1:0] status_q, set_ev;

  // a locked block refuses a packet from its first byte; drop_q covers the rest
  assign drop_eff = drop_q || (wr_tag.first && lock_q);
  assign ovf_ev   = wr_req && !drop_eff && fifo_full;
  assign fifo_wr  = wr_req && !drop_eff && !fifo_full;

  hdlc_rx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (fifo_wr),
    .wr_data_i({wr_tag, wr_data}),
    .rd_i     (rd_i),
    .rd_data_o(ent),
    .empty_o  (fifo_empty),
    .full_o   (fifo_full),
    .level_o  (level)
  );

  assign rd_data_o = ent[7:0];
  assign rd_tag_o  = ent[ENT_W-1:8];
  assign empty_o   = fifo_empty;
  assign hwm_thr   = LW'(hwm_sel_i) * LW'(WM_STEP) + LW'(WM_STEP / 2);

  always_comb begin
    set_ev           = '0;
    set_ev[ST_START] = fifo_wr && wr_tag.first;
    set_ev[ST_END]   = fifo_wr && wr_tag.last;
    set_ev[ST_ABORT] = abort_ev;
    set_ev[ST_HWM]   = level > hwm_thr;
    set_ev[ST_OVF]   = ovf_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q   <= 1'b0;
      lock_q   <= 1'b0;
      status_q <= '0;
    end else begin
      if (ovf_ev)          lock_q <= 1'b1;
      else if (fifo_empty) lock_q <= 1'b0;
      if (wr_req)          drop_q <= wr_tag.last ? 1'b0 : (drop_eff || fifo_full);
      status_q <= (status_q & ~clr_i) | set_ev;
    end
  end

  assign status_o = status_q;

  // R10: while locked, no new packet reaches the FIFO
  a_r10_lock_blocks_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_tag.first) |-> !fifo_wr);

  // R8: storing a first byte raises the start flag on the next cycle
  a_r8_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr && wr_tag.first) |=> status_q[ST_START]);

  // R11: a set flag stays until cleared
  a_r11_end_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[ST_END] && !clr_i[ST_END]) |=> status_q[ST_END]);

endmodule

// File: tb/hdlc_rx_core_tb_top.sv
module hdlc_rx_core_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, bit_v, rd;
  logic [2:0] hwm_sel;
  logic [4:0] clr;
  logic [7:0] rd_data;
  logic [3:0] rd_tag;
  logic       empty;
  logic [4:0] status;

  always #(CLK_P/2) clk = ~clk;

  hdlc_rx_core #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v), .rd_i(rd),
    .hwm_sel_i(hwm_sel), .clr_i(clr), .rd_data_o(rd_data), .rd_tag_o(rd_tag),
    .empty_o(empty), .status_o(status)
  );

  int checks = 0, fails = 0;
  logic [11:0] exp_q[$];
  logic [4:0]  exp_st = '0;
  logic [4:0]  clr_hold = '0;
  logic [7:0]  pay [0:31];
  bit rd_rand = 0, m_lock = 0, m_drop = 0;
  int ones_tx = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  // bench model of store, drop and overflow rules (R6, R8, R9, R10)
  task automatic m_write(bit first, bit last, logic [1:0] st, logic [7:0] d);
    if (m_drop || (first && m_lock)) begin m_drop = !last; return; end
    if (exp_q.size() >= DEPTH) begin exp_st[4] = 1; m_lock = 1; m_drop = !last; return; end
    exp_q.push_back({st, last, first, d});
    if (first) exp_st[0] = 1;
    if (last)  exp_st[1] = 1;
    if (exp_q.size() > 32*hwm_sel + 16) exp_st[3] = 1;
  endtask

  task automatic rand_read();
    logic [11:0] w;
    rd = 1'b0;
    if (rd_rand && !empty && $urandom_range(0, 1) == 1) begin
      w = (exp_q.size() != 0) ? exp_q.pop_front() : 12'hEEE;
      chk("R7 concurrent read", {rd_tag, rd_data}, w);
      rd = 1'b1;
    end
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    while ($urandom_range(0, 3) == 0) begin
      bit_en = 0; bit_v = 1'($urandom); clr = clr_hold; rand_read();
      @(negedge clk);
    end
    bit_en = 1; bit_v = b; clr = clr_hold; rand_read();
  endtask

  task automatic idle_cyc();
    @(negedge clk);
    bit_en = 0; rd = 0; clr = 0;
  endtask

  task automatic send_flag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) send_bit(f[i]);
    ones_tx = 0;
  endtask

  task automatic send_sbyte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      ones_tx = b[i] ? ones_tx + 1 : 0;
      if (ones_tx == 5) begin send_bit(1'b0); ones_tx = 0; end
    end
  endtask

  // kind: 0 good, 1 bad CRC, 2 short (no check bytes), 3 abort after k bytes
  task automatic send_frame(int n, int kind, int k);
    logic [15:0] c;
    int h, li;
    c = 16'hFFFF;
    if (kind == 3) begin
      exp_st[2] = 1;
      if (k > 0) begin
        h = (k < 3) ? k : 3;
        li = k - h;
        for (int i = 0; i <= li; i++) m_write(i == 0, i == li, (i == li) ? 2'd2 : 2'd0, pay[i]);
      end
    end else if (kind == 2) m_write(1, 1, 2'd1, pay[0]);
    else for (int i = 0; i < n; i++) m_write(i == 0, i == n-1, (i == n-1 && kind == 1) ? 2'd1 : 2'd0, pay[i]);
    send_flag();
    if (kind == 3) begin
      for (int i = 0; i < k; i++) send_sbyte(pay[i]);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
    end else begin
      for (int i = 0; i < n; i++) begin send_sbyte(pay[i]); c = crc_b(c, pay[i]); end
      if (kind != 2) begin
        c = ~c;
        if (kind == 1) c[3] = ~c[3];
        send_sbyte(c[7:0]);
        send_sbyte(c[15:8]);
      end
    end
    send_flag();
  endtask

  task automatic rand_pay(int n);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
  endtask

  task automatic drain(string req);
    int n;
    logic [11:0] w;
    n = 0;
    idle_cyc();
    repeat (3) idle_cyc();
    while (!empty && n < 600) begin
      w = (exp_q.size() != 0) ? exp_q.pop_front() : 12'hEEE;
      chk(req, {rd_tag, rd_data}, w);
      rd = 1'b1;
      n++;
      @(negedge clk);
    end
    rd = 1'b0;
    chk({req, " leftover"}, exp_q.size(), 0);
    chk({req, " empty"}, empty, 1);
    m_lock = 0;
  endtask

  task automatic check_status(string req, logic [4:0] mask);
    repeat (3) idle_cyc();
    chk(req, status & mask, exp_st & mask);
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 5'h1F;
    @(negedge clk); clr = 5'h00;
    exp_st = '0;
    chk("R11 clear", status, 5'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; bit_en = 0; bit_v = 0; rd = 0; clr = 0; hwm_sel = 3'd7;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 empty after reset", empty, 1);
    chk("R12 status after reset", status, 0);

    // R7: read while empty is ignored
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
    chk("R7 empty read ignored", empty, 1);

    // R1: flags only store nothing
    repeat (4) send_flag();
    repeat (3) idle_cyc();
    chk("R1 flags only", empty, 1);

    // R1/R3: one-byte good frame
    pay[0] = 8'hA5; send_frame(1, 0, 0); drain("R1");
    // R2: payload with stuffing-heavy bytes
    pay[0] = 8'hFF; pay[1] = 8'h7E; pay[2] = 8'h1F; pay[3] = 8'hF8; pay[4] = 8'h3F;
    send_frame(5, 0, 0); drain("R2");
    // R3: bad CRC and short frames
    rand_pay(4); send_frame(4, 1, 0);
    pay[0] = 8'h11; pay[1] = 8'h22; send_frame(2, 2, 0);
    drain("R3");
    // R6: aborts at several depths
    rand_pay(8); send_frame(0, 3, 0);
    rand_pay(8); send_frame(0, 3, 1);
    rand_pay(8); send_frame(0, 3, 2);
    rand_pay(8); send_frame(0, 3, 5);
    drain("R6");
    check_status("R5 abort flag", 5'b00100);
    check_status("R8 start/end flags", 5'b00011);
    clear_all();

    // R9: watermark at threshold 16
    hwm_sel = 3'd0;
    rand_pay(16); send_frame(16, 0, 0);
    check_status("R9 level 16 not above", 5'b01000);
    chk("R9 flag low at 16", status[3], 0);
    rand_pay(1); send_frame(1, 0, 0);
    check_status("R9 level 17 above", 5'b01000);
    chk("R9 flag high at 17", status[3], 1);
    drain("R9");
    clear_all();
    hwm_sel = 3'd7;

    // R11: set and clear on the same edge
    clr_hold = 5'b00011;
    rand_pay(5); send_frame(5, 0, 0);
    clr_hold = 5'b00000;
    idle_cyc();
    chk("R11 set wins over clear", status[1:0], 2'b10);
    exp_st = '0;
    drain("R11");
    clear_all();

    // R4: random frames, tags checked on drain
    for (int f = 0; f < 15; f++) begin
      int n, kind;
      n = $urandom_range(1, 12);
      kind = $urandom_range(0, 9);
      rand_pay(n);
      if (kind < 6)       send_frame(n, 0, 0);
      else if (kind < 8)  send_frame(n, 1, 0);
      else                send_frame(0, 3, $urandom_range(0, 6));
    end
    drain("R4");
    check_status("R4 status after random", 5'b11111);
    clear_all();

    // R7: reads concurrent with reception
    rd_rand = 1;
    for (int f = 0; f < 20; f++) begin
      int n;
      n = $urandom_range(1, 10);
      rand_pay(n);
      if (f % 5 == 4) send_frame(0, 3, $urandom_range(1, 5));
      else            send_frame(n, f % 3 == 2 ? 1 : 0, 0);
    end
    rd_rand = 0;
    drain("R7");
    check_status("R7 status after concurrent", 5'b00111);
    clear_all();

    // R10: overflow and lockout until empty
    for (int f = 0; f < 18; f++) begin rand_pay(16); send_frame(16, 0, 0); end
    check_status("R10 overflow flag", 5'b10000);
    chk("R10 overflow raised", status[4], 1);
    drain("R10");
    rand_pay(3); send_frame(3, 0, 0);
    drain("R10 after empty");
    check_status("R10 final status", 5'b11111);
    clear_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule